// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

A four-bit up-counter whose flip-flops share one rising clock edge, so all count bits change together. It can be preset from four data inputs, cleared to zero, held, or advanced. Counting needs two enables, P and T, both high. Only T feeds the carry output, which is high while T is high and the count is at all ones. Several stages chain into a wider synchronous counter with no extra gates: each stage's carry drives the T enable of the stage above, and P is shared.

A parameter fixes how the active-low clear behaves. The asynchronous variant zeroes the count at once. The synchronous variant zeroes it on the next rising edge. With the synchronous variant, a decode of a chosen terminal count fed back to the clear shortens the counting cycle.

Top module: `casc_sync_counter`

## Requirements
- R1: With `clr_n` low, `q` is 0 after the next rising edge, whatever `load_n`, `en_p` and `en_t` are.
- R2: With `clr_n` high and `load_n` low, the next rising edge copies `din` to `q`, whatever the enables are.
- R3: With `clr_n` and `load_n` high and both `en_p` and `en_t` high, each rising edge adds one to `q`, and 15 wraps to 0.
- R4: With `clr_n` and `load_n` high and `en_p` or `en_t` low, `q` keeps its value across the edge.
- R5: `rco` is 1 exactly when `en_t` is 1 and `q` is 15. It follows these inputs without a clock and does not depend on `en_p`.
- R6: Stages chained with carry into the next stage's `en_t`, and a common enable on every `en_p` and on the first stage's `en_t`, form one wider counter. It advances by one on each edge where the common enable is high.
- R7: In synchronous clear mode, feeding back a decode of `q == N` to `clr_n` makes the counter run 0, 1, …, N, 0.
- R8: In synchronous clear mode, a low `clr_n` overrides a low `load_n` on the same edge, giving 0.
- R9: In asynchronous clear mode (`CLR_SYNC = 0`), `q` becomes 0 as soon as `clr_n` falls, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; its timing is set by `CLR_SYNC` |
| load_n | input | 1 | Active-low synchronous preset |
| din | input | WIDTH | Preset value |
| en_p | input | 1 | Count enable that does not reach the carry |
| en_t | input | 1 | Count enable that also qualifies the carry |
| q | output | WIDTH | Count value |
| rco | output | 1 | Ripple carry: `en_t` and all-ones count |

## Verification
Clear, load and count can all be requested on the same edge. The bench provokes this with directed edges where a low clear meets a low load and high enables, and with a long random phase that often drives several controls low together. A behavioural model applies the priority clear, then load, then count, then hold, and compares the count and carry after every edge. A separate asynchronous instance also has its clear dropped in the middle of a cycle, and its count is checked before the next edge.

// File: rtl/cnt_pkg.sv
// Package: shared operation code for the counter stage.
// Assumes: used by every module of the counter.
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
// Module: cnt_ctrl
// Picks the operation for the coming clock edge: clear, then load,
// then count, then hold.
// Assumes: all controls are active as given at the ports; it is purely combinational.
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);
    // Priority decode of the controls
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_reg.sv
// Module: cnt_reg
// Count register. CLR_SYNC picks the clear variant: 1 clears on the
// edge, 0 clears as soon as clr_n falls.
// Assumes: op comes from cnt_ctrl and has clear ranked first.
module cnt_reg
    import cnt_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter bit CLR_SYNC = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_nxt;

    // Next-value selection for the chosen operation
    always_comb begin
        case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = din;
            OP_COUNT: q_nxt = q_r + WIDTH'(1);
            default:  q_nxt = q_r;
        endcase
    end

    generate
        if (CLR_SYNC) begin : g_sync_clr
            // Every change, the clear included, happens on the edge
            always_ff @(posedge clk) begin
                q_r <= q_nxt;
            end
        end else begin : g_async_clr
            // The clear acts at once; the rest happens on the edge
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    q_r <= '0;
                else
                    q_r <= q_nxt;
            end
        end
    endgenerate

    assign q = q_r;

    // R1: a low clear at one edge leaves zero seen at the next
    a_r1_clear_zero: assert property (@(posedge clk) !clr_n |=> q == '0)
        else $error("a_r1_clear_zero");
endmodule

// File: rtl/cnt_carry.sv
// Module: cnt_carry
// Look-ahead carry: high while en_t is high and the count is all ones.
// Assumes: q is the registered count; the output is combinational.
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             rco
);
    localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};

    // Terminal-count decode qualified by T only
    always_comb begin
        rco = en_t && (q == TERMINAL);
    end
endmodule

// File: rtl/casc_sync_counter.sv
// Module: casc_sync_counter
// Presettable synchronous binary counter stage with a split count enable
// and a look-ahead carry, meant for chaining.
// Assumes: one clock; clr_n timing is set by CLR_SYNC.
module casc_sync_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter bit CLR_SYNC = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             rco
);
    cnt_op_e op;

    cnt_ctrl u_ctrl (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    cnt_reg #(.WIDTH(WIDTH), .CLR_SYNC(CLR_SYNC)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .q     (q)
    );

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .q    (q),
        .en_t (en_t),
        .rco  (rco)
    );

    // R2: a preset copies the data whatever the enables are
    a_r2_load: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din))
        else $error("a_r2_load");

    // R3: counting adds one, with wrap
    a_r3_count: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> q == WIDTH'($past(q) + WIDTH'(1)))
        else $error("a_r3_count");

    // R4: without both enables the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q))
        else $error("a_r4_hold");

    // R5: a carry with P high and no preset is followed by a wrap to zero
    a_r5_carry_wrap: assert property (@(posedge clk) disable iff (!clr_n)
        (rco && en_p && load_n) |=> q == '0)
        else $error("a_r5_carry_wrap");
endmodule

// File: tb/casc_sync_counter_tb.sv
`timescale 1ns/1ps
module casc_sync_counter_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Shared stimulus for the sync (u_dut) and async (u_async) stages
    logic       s_clr_n = 1'b0, a_clr_n = 1'b0;
    logic       load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] s_q, a_q;
    logic       s_rco, a_rco;

    casc_sync_counter #(.WIDTH(4), .CLR_SYNC(1'b1)) u_dut (
        .clk(clk), .clr_n(s_clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(s_q), .rco(s_rco));

    casc_sync_counter #(.WIDTH(4), .CLR_SYNC(1'b0)) u_async (
        .clk(clk), .clr_n(a_clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(a_q), .rco(a_rco));

    // Three-stage chain (R6)
    logic       c_clr_n = 1'b0, cen = 1'b0;
    logic [3:0] cq [3];
    logic       crc [3];
    for (genvar k = 0; k < 3; k++) begin : g_chain
        casc_sync_counter #(.WIDTH(4), .CLR_SYNC(1'b1)) u_stage (
            .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .din(4'd0),
            .en_p(cen), .en_t((k == 0) ? cen : crc[(k == 0) ? 0 : k - 1]),
            .q(cq[k]), .rco(crc[k]));
    end

    // Shortened count with decode feedback to 9 (R7)
    logic       h_rst_n = 1'b0;
    logic [3:0] h_q;
    logic       h_rco;
    logic       h_clr_n;
    assign h_clr_n = h_rst_n && (h_q != 4'd9);
    casc_sync_counter #(.WIDTH(4), .CLR_SYNC(1'b1)) u_short (
        .clk(clk), .clr_n(h_clr_n), .load_n(1'b1), .din(4'd0),
        .en_p(1'b1), .en_t(1'b1), .q(h_q), .rco(h_rco));

    // Behavioural reference models
    int    sm = 0, am = 0, cm = 0, hm = 0;
    string s_tag = "R1", a_tag = "R1";

    always @(posedge clk) begin
        if (!s_clr_n) begin
            sm <= 0; s_tag <= (!load_n) ? "R8" : "R1";
        end else if (!load_n) begin
            sm <= din; s_tag <= "R2";
        end else if (en_p && en_t) begin
            sm <= (sm + 1) % 16; s_tag <= "R3";
        end else begin
            s_tag <= "R4";
        end
        if (!c_clr_n) cm <= 0;
        else if (cen) cm <= (cm + 1) % 4096;
        if (!h_rst_n || hm == 9) hm <= 0;
        else hm <= hm + 1;
    end

    always @(posedge clk or negedge a_clr_n) begin
        if (!a_clr_n) begin
            am <= 0; a_tag <= "R9";
        end else if (!load_n) begin
            am <= din; a_tag <= "R2";
        end else if (en_p && en_t) begin
            am <= (am + 1) % 16; a_tag <= "R3";
        end else begin
            a_tag <= "R4";
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare every stage with its model away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(s_tag, s_q, sm);
            chk("R5", s_rco, (en_t && sm == 15) ? 1 : 0);
            chk(a_tag, a_q, am);
            chk("R5", a_rco, (en_t && am == 15) ? 1 : 0);
            chk("R6", {cq[2], cq[1], cq[0]}, cm);
            chk("R7", h_q, hm);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        // R1: reset state with both clears low
        load_n = 1'b0; din = 4'd7; en_p = 1'b1; en_t = 1'b1;
        tick(3);
        chk("R1", s_q, 0);
        chk("R1", a_q, 0);
        s_clr_n = 1'b1; a_clr_n = 1'b1; c_clr_n = 1'b1; h_rst_n = 1'b1;
        load_n = 1'b1; cen = 1'b1;
        // R3: count through a wrap
        tick(20);
        // R4: hold patterns
        en_p = 1'b0; tick(4);
        en_p = 1'b1; en_t = 1'b0; tick(4);
        en_p = 1'b0; tick(4);
        // R5: carry at 15 with P low, then T low
        load_n = 1'b0; din = 4'd15; tick(1);
        load_n = 1'b1; en_p = 1'b0; en_t = 1'b1; tick(1);
        chk("R5", s_rco, 1);
        en_t = 1'b0; #0.5 chk("R5", s_rco, 0);
        // R2: preset with the enables low
        tick(1);
        load_n = 1'b0; din = 4'd10; tick(1);
        chk("R2", s_q, 10);
        // R8: sync clear beats load
        s_clr_n = 1'b0; din = 4'd5; en_p = 1'b1; en_t = 1'b1; tick(1);
        chk("R8", s_q, 0);
        s_clr_n = 1'b1; load_n = 1'b1; tick(5);
        // R9: async clear in mid-cycle
        a_clr_n = 1'b0; #0.5;
        chk("R9", a_q, 0);
        tick(1);
        a_clr_n = 1'b1; tick(3);
        // Random phase mixing all controls
        for (int i = 0; i < 5000; i++) begin
            en_p    = ($urandom % 4) != 0;
            en_t    = ($urandom % 4) != 0;
            load_n  = ($urandom % 8) != 0;
            din     = 4'($urandom);
            s_clr_n = ($urandom % 16) != 0;
            a_clr_n = ($urandom % 16) != 0;
            cen     = ($urandom % 8) != 0;
            tick(1);
        end
        finish_run();
    end
endmodule